// File: doc/BRIEF.md
# Chained Counter Watchdog Timer

This block holds a small bank of 64-bit down-counters behind a word-wide register port. Each counter has a control word (enable, mode, trigger source, prescaler, plus a read-only busy flag) and a reload value written as two 32-bit halves. A counter counts its reload value down to zero, stepping once every prescaler clock cycles. When it reaches zero it raises a one-cycle end event.

Two counter behaviours are provided. A single-run counter starts when software enables it. An externally started counter waits for the end event of the counter just below it. The highest counter in the default build is the watchdog. It runs in the externally started mode and is chained to counter 0, which has a reload of zero. Each time software toggles counter 0's enable, counter 0 fires at once and restarts the watchdog from its full reload value. If the kicks stop and the watchdog reaches zero while a role bit in the select register is set, the block raises a reset request for one cycle.

Top module: `wdc_top`

## Requirements
- R1: After reset every control word, count word and the select register read 0, and resetReq is low.
- R2: Counter i's control word is at byte address i*0x10. The low count word is at +0x4 and the high count word at +0x8. The select register is at 0x20. Writes to the count words set the reload value, and reads return the live count.
- R3: Control word layout: bit 0 is enable and bit 1 is the busy flag, which is read-only and unaffected by writes. Bits [3:2] are the mode (00 single-run, 11 externally started), bits [7:4] are the trigger source (5 = end event of counter i-1) and bits [15:8] are the prescaler. Bits [31:16] read 0.
- R4: In single-run mode, a 0-to-1 write of enable loads the reload value N and sets busy. The count drops by one every P cycles. Busy clears and the end event fires N*P cycles after the enabling write.
- R5: A prescaler field below 2 behaves exactly like 2.
- R6: In single-run mode with a reload of 0, enabling fires the end event at once and busy never rises. Clearing and then setting enable fires it again.
- R7: In externally started mode, enabling alone starts nothing. The end event of counter i-1, with trigger source 5, reloads the count and starts it. A further event while the counter is running restarts it from the reload value.
- R8: When counter 1 reaches zero while select bit 1 is set, resetReq is high for exactly one cycle. With the bit clear, the counter still expires but resetReq stays low.
- R9: When counter 1 has a reload of 0 and is triggered, it expires at once: resetReq rises in the cycle after counter 0's end event.
- R10: Clearing enable drops busy and freezes the count. While a counter is not busy its count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one word per cycle |
| addr | input | 8 | Byte address of the word being read or written |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| resetReq | output | 1 | One-cycle watchdog expiry request |

## Verification
The checker watches properties that must hold on every cycle. An end event always coincides with a zero count and a cleared busy flag. Busy never stands without enable, and a disable write drops busy on the next cycle. An idle counter keeps its count, and a reset request never lasts two cycles. Other behaviour can only be shown by the bench's scenarios. These include the exact expiry cycle for a given reload and prescaler, and the prescaler floor. They also cover the difference between the two modes, and whether a kick really pushes expiry out. The bench also shows that a cleared select bit suppresses the request.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int PRESC_W = 8;
  localparam logic [PRESC_W-1:0] PRESC_FLOOR = 8'd2;
  localparam logic [1:0] MODE_HWSIG = 2'b11;
  localparam logic [3:0] SRC_PREV_END = 4'h5;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_LO = 4'h4;
  localparam logic [3:0] OFF_HI = 4'h8;

  typedef struct packed {
    logic start;
    logic stop;
    logic loadLo;
    logic loadHi;
  } cntStrobe_t;

  typedef struct packed {
    logic en;
    logic [1:0] mode;
    logic [3:0] src;
    logic [PRESC_W-1:0] presc;
  } cntCfg_t;
endpackage

// File: rtl/wdc_regctl.sv
module wdc_regctl
  import wdc_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int WD_IDX = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] liveCnt,
  input  logic [NUM_CNT-1:0] active,
  output cntCfg_t [NUM_CNT-1:0] cfg,
  output cntStrobe_t [NUM_CNT-1:0] strb,
  output logic selWd,
  output logic [DATA_W-1:0] rdData
);
  localparam int IDX_W = ADDR_W - 4;
  localparam int SEL_IDX = NUM_CNT;
  localparam int PAD_W = DATA_W - 16;

  logic [IDX_W-1:0] idx;
  logic [3:0] off;
  cntCfg_t [NUM_CNT-1:0] cfgQ;
  logic selQ;

  assign idx = addr[ADDR_W-1:4];
  assign off = addr[3:0];
  assign cfg = cfgQ;
  assign selWd = selQ;

  // decode writes into per-counter strobes
  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      logic hit;
      logic ctrlWr;
      hit = wrEn && (idx == IDX_W'(i));
      ctrlWr = hit && (off == OFF_CTRL);
      strb[i].start = ctrlWr && wrData[0] && !cfgQ[i].en && (wrData[3:2] != MODE_HWSIG);
      strb[i].stop = ctrlWr && !wrData[0] && cfgQ[i].en;
      strb[i].loadLo = hit && (off == OFF_LO);
      strb[i].loadHi = hit && (off == OFF_HI);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
      selQ <= 1'b0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (idx == IDX_W'(i) && off == OFF_CTRL) begin
          cfgQ[i].en <= wrData[0];
          cfgQ[i].mode <= wrData[3:2];
          cfgQ[i].src <= wrData[7:4];
          cfgQ[i].presc <= wrData[15:8];
        end
      end
      if (idx == IDX_W'(SEL_IDX) && off == OFF_CTRL) selQ <= wrData[WD_IDX];
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (idx == IDX_W'(i)) begin
        case (off)
          OFF_CTRL: rdData = {{PAD_W{1'b0}}, cfgQ[i].presc, cfgQ[i].src, cfgQ[i].mode,
                              active[i], cfgQ[i].en};
          OFF_LO: rdData = liveCnt[i][DATA_W-1:0];
          OFF_HI: rdData = liveCnt[i][CNT_W-1:DATA_W];
          default: rdData = '0;
        endcase
      end
    end
    if (idx == IDX_W'(SEL_IDX) && off == OFF_CTRL) rdData[WD_IDX] = selQ;
  end
endmodule

// File: rtl/wdc_datapath.sv
module wdc_datapath
  import wdc_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W = 64,
  parameter int DATA_W = 32
) (
  input  logic clk,
  input  logic rstN,
  input  cntStrobe_t [NUM_CNT-1:0] strb,
  input  cntCfg_t [NUM_CNT-1:0] cfg,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_CNT-1:0][CNT_W-1:0] liveCnt,
  output logic [NUM_CNT-1:0] active,
  output logic [NUM_CNT-1:0] endEvt
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : gCnt
    logic [CNT_W-1:0] reloadQ;
    logic [CNT_W-1:0] cntQ;
    logic [PRESC_W-1:0] tickQ;
    logic [PRESC_W-1:0] effPresc;
    logic actQ;
    logic evtQ;
    logic prevEvt;
    logic trigHit;
    logic fire;

    if (i == 0) begin : gFirst
      assign prevEvt = 1'b0;
    end else begin : gChain
      assign prevEvt = endEvt[i-1];
    end

    assign effPresc = (cfg[i].presc < PRESC_FLOOR) ? PRESC_FLOOR : cfg[i].presc;
    assign trigHit = cfg[i].en && (cfg[i].mode == MODE_HWSIG) &&
                     (cfg[i].src == SRC_PREV_END) && prevEvt;
    assign fire = strb[i].start || trigHit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reloadQ <= '0;
        cntQ <= '0;
        tickQ <= '0;
        actQ <= 1'b0;
        evtQ <= 1'b0;
      end else begin
        evtQ <= 1'b0;
        if (strb[i].loadLo) reloadQ[DATA_W-1:0] <= wrData;
        if (strb[i].loadHi) reloadQ[CNT_W-1:DATA_W] <= wrData;
        if (strb[i].stop) begin
          actQ <= 1'b0;
          tickQ <= '0;
        end else if (fire) begin
          tickQ <= '0;
          if (reloadQ == '0) begin
            cntQ <= '0;
            actQ <= 1'b0;
            evtQ <= 1'b1;
          end else begin
            cntQ <= reloadQ;
            actQ <= 1'b1;
          end
        end else if (actQ) begin
          if (tickQ == effPresc - 8'd1) begin
            tickQ <= '0;
            cntQ <= cntQ - 1'b1;
            if (cntQ == CNT_W'(1)) begin
              actQ <= 1'b0;
              evtQ <= 1'b1;
            end
          end else begin
            tickQ <= tickQ + 8'd1;
          end
        end
      end
    end

    assign liveCnt[i] = cntQ;
    assign active[i] = actQ;
    assign endEvt[i] = evtQ;
  end
endmodule

// File: rtl/wdc_top.sv
module wdc_top
  import wdc_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int WD_IDX = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic resetReq
);
  cntCfg_t [NUM_CNT-1:0] cfg;
  cntStrobe_t [NUM_CNT-1:0] strb;
  logic [NUM_CNT-1:0][CNT_W-1:0] liveCnt;
  logic [NUM_CNT-1:0] active;
  logic [NUM_CNT-1:0] endEvt;
  logic selWd;

  wdc_regctl #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WD_IDX(WD_IDX)
  ) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .liveCnt(liveCnt), .active(active), .cfg(cfg), .strb(strb),
    .selWd(selWd), .rdData(rdData)
  );

  wdc_datapath #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .wrData(wrData),
    .liveCnt(liveCnt), .active(active), .endEvt(endEvt)
  );

  assign resetReq = endEvt[WD_IDX] && selWd;
endmodule

// File: rtl/wdc_checker.sv
module wdc_checker
  import wdc_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W = 64
) (
  input logic clk,
  input logic rstN,
  input logic resetReq,
  input cntCfg_t [NUM_CNT-1:0] cfg,
  input cntStrobe_t [NUM_CNT-1:0] strb,
  input logic [NUM_CNT-1:0][CNT_W-1:0] liveCnt,
  input logic [NUM_CNT-1:0] active,
  input logic [NUM_CNT-1:0] endEvt
);
  // R8: the request is a single-cycle pulse
  p_req_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  for (genvar i = 0; i < NUM_CNT; i++) begin : gChk
    // R4: an end event means the count has reached zero
    p_end_at_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
      endEvt[i] |-> (liveCnt[i] == '0));
    // R4: busy is clear when the end event fires
    p_end_not_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
      endEvt[i] |-> !active[i]);
    // R10: busy never stands without enable
    p_busy_needs_en_r10: assert property (@(posedge clk) disable iff (!rstN)
      active[i] |-> cfg[i].en);
    // R10: a disable write idles the counter on the next cycle
    p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].stop |=> !active[i]);
    // R10: an idle counter keeps its count
    p_idle_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
      (!active[i] && !endEvt[i]) |-> $stable(liveCnt[i]));
  end
endmodule

bind wdc_top wdc_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .resetReq(resetReq), .cfg(cfg), .strb(strb),
  .liveCnt(liveCnt), .active(active), .endEvt(endEvt)
);

// File: tb/tb_wdc_top.sv
module tb_wdc_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic resetReq;

  int cyc = 0;
  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    int at;
    string tag;
  } reqExp_t;
  reqExp_t reqQ[$];

  wdc_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .resetReq(resetReq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    addr = a;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic waitTo(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic longint cntAt(input longint n, input int p, input int s, input int c);
    longint d;
    d = longint'((c - s) / p);
    return (d >= n) ? 64'd0 : n - d;
  endfunction

  task automatic pushReq(input int at, input string tag);
    reqExp_t e;
    e.at = at;
    e.tag = tag;
    reqQ.push_back(e);
  endtask

  // monitor: every request pulse must match the head of the expected queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (resetReq) begin
        nRun++;
        if (reqQ.size() == 0) begin
          nFail++;
          $display("FAIL R8: unexpected resetReq actual cycle %0d expected none", cyc);
        end else begin
          reqExp_t e;
          e = reqQ.pop_front();
          if (e.at != cyc) begin
            nFail++;
            $display("FAIL %s: resetReq actual cycle %0d expected %0d", e.tag, cyc, e.at);
          end
        end
      end else if (reqQ.size() > 0 && reqQ[0].at < cyc) begin
        reqExp_t e;
        e = reqQ.pop_front();
        nRun++;
        nFail++;
        $display("FAIL %s: resetReq actual none expected cycle %0d", e.tag, e.at);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int s;
    int w;
    int t;
    longint v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rdChk(8'h00, 32'h0, "R1 ctrl0");
    rdChk(8'h10, 32'h0, "R1 ctrl1");
    rdChk(8'h04, 32'h0, "R1 count0 low");
    rdChk(8'h20, 32'h0, "R1 select");
    chk("R1 resetReq", {31'b0, resetReq}, 32'h0);

    // R3: field layout, busy flag read-only
    wr(8'h00, 32'h0000_0552);
    rdChk(8'h00, 32'h0000_0550, "R3 ctrl readback");
    wr(8'h00, 32'h0);

    // R4: single-run, N=5, P=3
    wr(8'h04, 32'd5);
    wr(8'h08, 32'd0);
    wr(8'h00, 32'h0000_0301);
    s = cyc;
    rdChk(8'h04, 32'd5, "R4 loaded");
    rdChk(8'h00, 32'h0000_0303, "R4 busy");
    waitTo(s + 7);
    rdChk(8'h04, 32'd3, "R4 mid count");
    waitTo(s + 14);
    rdChk(8'h00, 32'h0000_0303, "R4 busy before end");
    waitTo(s + 15);
    rdChk(8'h04, 32'd0, "R4 end count");
    rdChk(8'h00, 32'h0000_0301, "R4 busy cleared");

    // R2: high word handling
    wr(8'h00, 32'h0000_0200);
    wr(8'h04, 32'd0);
    wr(8'h08, 32'd1);
    wr(8'h00, 32'h0000_0201);
    s = cyc;
    rdChk(8'h08, 32'd1, "R2 high word");
    rdChk(8'h04, 32'd0, "R2 low word");
    waitTo(s + 2);
    rdChk(8'h08, 32'd0, "R2 high borrow");
    rdChk(8'h04, 32'hFFFF_FFFF, "R2 low borrow");

    // R10: disable freezes
    waitTo(s + 9);
    wr(8'h00, 32'h0000_0200);
    t = cyc;
    v = cntAt(64'h1_0000_0000, 2, s, t - 1);
    waitTo(t + 6);
    rdChk(8'h04, v[31:0], "R10 frozen count");
    rdChk(8'h00, 32'h0000_0200, "R10 busy dropped");

    // R5: prescaler 0 and 1 behave as 2
    wr(8'h04, 32'd4);
    wr(8'h08, 32'd0);
    wr(8'h00, 32'h0000_0001);
    s = cyc;
    waitTo(s + 7);
    rdChk(8'h00, 32'h0000_0003, "R5 presc0 still busy");
    waitTo(s + 8);
    rdChk(8'h00, 32'h0000_0001, "R5 presc0 done");
    wr(8'h00, 32'h0000_0000);
    wr(8'h00, 32'h0000_0101);
    s = cyc;
    waitTo(s + 3);
    rdChk(8'h04, 32'd3, "R5 presc1 step");
    wr(8'h00, 32'h0000_0000);

    // R7: externally started watchdog counter
    wr(8'h04, 32'd0);
    wr(8'h20, 32'h2);
    rdChk(8'h20, 32'h2, "R8 select set");
    wr(8'h14, 32'd10);
    wr(8'h18, 32'd0);
    wr(8'h10, 32'h0000_025D);
    repeat (4) @(negedge clk);
    rdChk(8'h10, 32'h0000_025D, "R7 enable alone idle");
    rdChk(8'h14, 32'd0, "R7 no load");

    // R6: zero-reload kick starts counter 1
    wr(8'h00, 32'h0000_0201);
    w = cyc;
    pushReq(w + 21, "R8");
    rdChk(8'h00, 32'h0000_0201, "R6 busy never set");
    waitTo(w + 1);
    rdChk(8'h14, 32'd10, "R7 triggered load");
    rdChk(8'h10, 32'h0000_025F, "R7 busy");

    // R7: retrigger before expiry
    waitTo(w + 9);
    wr(8'h00, 32'h0000_0200);
    wr(8'h00, 32'h0000_0201);
    w = cyc;
    reqQ.delete();
    pushReq(w + 21, "R7 kick delays expiry");
    waitTo(w + 1);
    rdChk(8'h14, 32'd10, "R7 retrigger reload");
    waitTo(w + 25);
    chk("R8 pulse consumed", 32'(reqQ.size()), 32'd0);

    // R8: role bit clear, no request
    wr(8'h20, 32'h0);
    rdChk(8'h20, 32'h0, "R8 select cleared");
    wr(8'h00, 32'h0000_0200);
    wr(8'h00, 32'h0000_0201);
    w = cyc;
    waitTo(w + 25);
    rdChk(8'h10, 32'h0000_025D, "R8 counter expired silently");
    rdChk(8'h14, 32'd0, "R8 count at zero");

    // R9: zero reload on watchdog, immediate expiry
    wr(8'h20, 32'h2);
    wr(8'h14, 32'd0);
    wr(8'h00, 32'h0000_0200);
    wr(8'h00, 32'h0000_0201);
    w = cyc;
    pushReq(w + 1, "R9");
    waitTo(w + 4);
    chk("R9 pulse consumed", 32'(reqQ.size()), 32'd0);

    repeat (3) @(negedge clk);
    while (reqQ.size() > 0) begin
      reqExp_t e;
      e = reqQ.pop_front();
      nRun++;
      nFail++;
      $display("FAIL %s: resetReq actual none expected cycle %0d", e.tag, e.at);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule